// File: doc/BRIEF.md
# Three-Cell Balancing Latch Controller

This block decides when the bleed resistors across a stack of series lithium cells are switched in. A measurement sequencer outside the block marks the start and end of each voltage poll. While a poll runs, it reports which cells are at or above the overvoltage limit. The block remembers each reported cell in a per-cell latch. When the poll ends it looks at the latches. If some cells are over the limit but not all of them, it turns on the bleed drive of each latched cell and asks the charge path to stay open.

Each bleed drive stays on until its own cell reports that it has fallen to the target level. The drives therefore drop out one at a time. The charge-hold request lasts until the last drive has dropped out. No balancing takes place when no cell is latched, or when every cell is latched. In sleep the drives and the request are forced inactive at once, and all latches are cleared. The drive polarity of each cell is a parameter. By default the highest cell is driven active high and the two lower cells active low.

Top module: `cell_balance_ctrl`

## Requirements
- R1: After reset, every bleed drive is at its inactive level (cells 0 and 1 high, cell 2 low, so `bal_drive` = 3'b011) and `charge_hold` is 0.
- R2: A cell whose `cell_ov` bit is high in any cycle of a poll is latched. When `poll_done` arrives with one or two cells latched, the drives of exactly those cells become active from the next clock edge.
- R3: If no cell was latched when `poll_done` arrives, no drive becomes active and `charge_hold` stays 0.
- R4: If every cell was latched when `poll_done` arrives, no drive becomes active and `charge_hold` stays 0.
- R5: `charge_hold` is 1 exactly while at least one drive is active.
- R6: An active drive whose `cell_at_target` bit is sampled high becomes inactive at the next edge. The drives of the other cells are not affected.
- R7: Bit i of `bal_drive` is the level for cell i. Bit 2 is active high and bits 0 and 1 are active low.
- R8: While `sleep` is high, all drives are inactive and `charge_hold` is 0 in that same cycle. The sleep cycle also clears all latches, so a later `poll_done` with no new overvoltage report starts no balancing.
- R9: While balancing is in progress, `poll_start` does not clear the latches and `poll_done` turns on no new drive. Overvoltage reports made during that time are still latched and are acted on at the next `poll_done` after balancing ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_start | input | 1 | One-cycle strobe at the start of a voltage poll |
| poll_done | input | 1 | One-cycle strobe at the end of a voltage poll |
| sleep | input | 1 | Low-power state; forces balancing off |
| cell_ov | input | NUM_CELLS | Per-cell overvoltage report |
| cell_at_target | input | NUM_CELLS | Per-cell "at or below target" report |
| bal_drive | output | NUM_CELLS | Per-cell bleed drive, with the polarity set per cell |
| charge_hold | output | 1 | Request to keep the charge switch off |

## Verification
Directed polls cover the following latch counts at `poll_done`: zero latched cells, two of three (cells 0 and 2), a single cell, and all three. Together these separate the skip rules of R3 and R4 from normal selection, and show that the drive pattern follows the polarity mask. One directed sequence releases the two cells on different cycles, which shows that the drives drop out one by one while `charge_hold` stays up until the last release. Another issues a poll start and a poll end during an active balance, then a bare poll end afterwards; this shows whether the latches survive and whether new selection is blocked. Sleep is raised in the middle of a balance and then followed by an empty poll, which shows both the same-cycle drive cut-off and the latch clear. A long seeded random run then mixes poll strobes, sparse overvoltage reports, target reports and occasional sleep. Every cycle of that run is compared against a reference model.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

   typedef enum logic [1:0] {
      LATCH_NONE    = 2'd0,
      LATCH_PARTIAL = 2'd1,
      LATCH_ALL     = 2'd2
   } latch_kind_e;

   function automatic latch_kind_e classify(input int unsigned set_count,
                                            input int unsigned total);
      if (set_count == 0)
         return LATCH_NONE;
      else if (set_count == total)
         return LATCH_ALL;
      else
         return LATCH_PARTIAL;
   endfunction

endpackage

// File: rtl/cbal_slice.sv
module cbal_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   input  logic clear_req,
   input  logic ov_seen,
   input  logic take,
   input  logic at_target,
   output logic latch_nxt,
   output logic bal_q
);

   logic latch_q;

   assign latch_nxt = (clear_req ? 1'b0 : latch_q) | ov_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
         bal_q   <= 1'b0;
      end else if (sleep) begin
         latch_q <= 1'b0;
         bal_q   <= 1'b0;
      end else begin
         latch_q <= latch_nxt;
         if (take)
            bal_q <= 1'b1;
         else if (at_target)
            bal_q <= 1'b0;
      end
   end

endmodule

// File: rtl/cbal_select.sv
module cbal_select
   import cbal_pkg::*;
#(
   parameter int NUM_CELLS     = 3,
   parameter bit SKIP_WHEN_ALL = 1'b1
) (
   input  logic [NUM_CELLS-1:0] latch_nxt,
   input  logic                 poll_done,
   input  logic                 busy,
   output logic [NUM_CELLS-1:0] take
);

   latch_kind_e kind;
   logic        eval;
   logic        allowed;

   assign kind = classify($countones(latch_nxt), NUM_CELLS);
   assign eval = poll_done & ~busy;

   generate
      if (SKIP_WHEN_ALL) begin : g_skip_all
         assign allowed = (kind == LATCH_PARTIAL);
      end else begin : g_keep_all
         assign allowed = (kind != LATCH_NONE);
      end
   endgenerate

   assign take = (eval && allowed) ? latch_nxt : '0;

endmodule

// File: rtl/cbal_drive.sv
module cbal_drive #(
   parameter int                   NUM_CELLS       = 3,
   parameter logic [NUM_CELLS-1:0] DRIVE_HIGH_MASK = 3'b100
) (
   input  logic [NUM_CELLS-1:0] bal_active,
   input  logic                 sleep,
   output logic [NUM_CELLS-1:0] drive
);

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_pol
      logic on;
      assign on = bal_active[i] & ~sleep;
      if (DRIVE_HIGH_MASK[i]) begin : g_high
         assign drive[i] = on;
      end else begin : g_low
         assign drive[i] = ~on;
      end
   end

endmodule

// File: rtl/cell_balance_ctrl.sv
module cell_balance_ctrl #(
   parameter int                   NUM_CELLS       = 3,
   parameter logic [NUM_CELLS-1:0] DRIVE_HIGH_MASK = 3'b100,
   parameter bit                   SKIP_WHEN_ALL   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 poll_start,
   input  logic                 poll_done,
   input  logic                 sleep,
   input  logic [NUM_CELLS-1:0] cell_ov,
   input  logic [NUM_CELLS-1:0] cell_at_target,
   output logic [NUM_CELLS-1:0] bal_drive,
   output logic                 charge_hold
);

   localparam int LAST_CELL = NUM_CELLS - 1;

   if (NUM_CELLS < 2) begin : g_bad_count
      $error("cell_balance_ctrl: NUM_CELLS must be at least 2");
   end
   if (LAST_CELL >= 32) begin : g_bad_width
      $error("cell_balance_ctrl: NUM_CELLS above 32 is not supported");
   end

   logic [NUM_CELLS-1:0] latch_nxt;
   logic [NUM_CELLS-1:0] bal_q;
   logic [NUM_CELLS-1:0] take;
   logic                 busy;
   logic                 clear_req;

   assign busy      = |bal_q;
   assign clear_req = poll_start & ~busy;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      cbal_slice u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .sleep     (sleep),
         .clear_req (clear_req),
         .ov_seen   (cell_ov[i]),
         .take      (take[i]),
         .at_target (cell_at_target[i]),
         .latch_nxt (latch_nxt[i]),
         .bal_q     (bal_q[i])
      );
   end

   cbal_select #(
      .NUM_CELLS     (NUM_CELLS),
      .SKIP_WHEN_ALL (SKIP_WHEN_ALL)
   ) u_select (
      .latch_nxt (latch_nxt),
      .poll_done (poll_done),
      .busy      (busy),
      .take      (take)
   );

   cbal_drive #(
      .NUM_CELLS       (NUM_CELLS),
      .DRIVE_HIGH_MASK (DRIVE_HIGH_MASK)
   ) u_drive (
      .bal_active (bal_q),
      .sleep      (sleep),
      .drive      (bal_drive)
   );

   assign charge_hold = busy & ~sleep;

endmodule

// File: rtl/cell_balance_chk.sv
module cell_balance_chk #(
   parameter int                   NUM_CELLS       = 3,
   parameter logic [NUM_CELLS-1:0] DRIVE_HIGH_MASK = 3'b100
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sleep,
   input logic [NUM_CELLS-1:0] cell_at_target,
   input logic [NUM_CELLS-1:0] bal_drive,
   input logic                 charge_hold
);

   localparam logic [NUM_CELLS-1:0] IDLE_LEVEL = ~DRIVE_HIGH_MASK;

   logic [NUM_CELLS-1:0] act;
   assign act = bal_drive ^ IDLE_LEVEL;

   assert_sleep_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (act == '0 && !charge_hold));

   assert_hold_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      charge_hold == (act != '0));

   assert_never_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(act) != NUM_CELLS);

   assert_no_join_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(charge_hold) && charge_hold) |-> ((act & ~$past(act)) == '0));

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_rel
      assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (act[i] && cell_at_target[i]) |=> !act[i]);
   end

endmodule

bind cell_balance_ctrl cell_balance_chk #(
   .NUM_CELLS       (NUM_CELLS),
   .DRIVE_HIGH_MASK (DRIVE_HIGH_MASK)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sleep          (sleep),
   .cell_at_target (cell_at_target),
   .bal_drive      (bal_drive),
   .charge_hold    (charge_hold)
);

// File: tb/cell_balance_ctrl_bench.sv
module cell_balance_ctrl_bench;

   localparam int   CLK_PERIOD = 10;
   localparam int   N          = 3;
   localparam logic [N-1:0] HIGH_MASK = 3'b100;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         poll_start = 1'b0, poll_done = 1'b0, sleep = 1'b0;
   logic [N-1:0] cell_ov = '0, cell_at_target = '0;
   logic [N-1:0] bal_drive;
   logic         charge_hold;

   int checks = 0;
   int errors = 0;

   logic [N-1:0] m_lat = '0;
   logic [N-1:0] m_bal = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cell_balance_ctrl u_cell_balance_ctrl (
      .clk(clk), .rst_n(rst_n), .poll_start(poll_start), .poll_done(poll_done),
      .sleep(sleep), .cell_ov(cell_ov), .cell_at_target(cell_at_target),
      .bal_drive(bal_drive), .charge_hold(charge_hold));

   function automatic logic [N-1:0] exp_drive(logic [N-1:0] b, logic s);
      logic [N-1:0] a;
      a = s ? '0 : b;
      return (a & HIGH_MASK) | (~a & ~HIGH_MASK);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_edge();
      logic [N-1:0] nl, nb;
      int c;
      if (sleep) begin
         m_lat = '0; m_bal = '0;
      end else begin
         nl = ((poll_start && m_bal == '0) ? '0 : m_lat) | cell_ov;
         nb = m_bal & ~cell_at_target;
         if (poll_done && m_bal == '0) begin
            c = $countones(nl);
            if (c != 0 && c != N) nb = nl;
         end
         m_lat = nl; m_bal = nb;
      end
   endtask

   // drive inputs for one cycle, check model outputs, advance
   task automatic step(input logic [N-1:0] ov, input logic [N-1:0] tg,
                       input logic ps, input logic pd, input logic sl);
      cell_ov = ov; cell_at_target = tg; poll_start = ps; poll_done = pd; sleep = sl;
      #1;
      check("R7 drive", 32'(bal_drive), 32'(exp_drive(m_bal, sl)));
      check("R5 hold", 32'(charge_hold), 32'((m_bal != '0) && !sl));
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step('0, '0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      logic [N-1:0] ov, tg;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      #1;
      check("R1 reset drive", 32'(bal_drive), 32'h3);
      check("R1 reset hold", 32'(charge_hold), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: empty poll
      step('0, '0, 1, 0, 0); step('0, '0, 0, 1, 0);
      #1; check("R3 no latch", 32'(bal_drive), 32'h3);
      idle(1);

      // R2 / R7: cells 0 and 2 latched
      step('0, '0, 1, 0, 0); step(3'b001, '0, 0, 0, 0); step(3'b100, '0, 0, 0, 0);
      step('0, '0, 0, 1, 0);
      #1; check("R2 R7 pattern", 32'(bal_drive), 32'h6);
      check("R5 hold on", 32'(charge_hold), 32'h1);
      // R6: staggered release
      step('0, 3'b001, 0, 0, 0);
      #1; check("R6 cell0 released", 32'(bal_drive), 32'h7);
      check("R6 hold kept", 32'(charge_hold), 32'h1);
      step('0, 3'b100, 0, 0, 0);
      #1; check("R6 all released", 32'(bal_drive), 32'h3);
      check("R6 hold dropped", 32'(charge_hold), 32'h0);

      // R4: all cells latched
      step('0, '0, 1, 0, 0); step(3'b111, '0, 0, 1, 0);
      #1; check("R4 all skip", 32'(bal_drive), 32'h3);
      idle(1);

      // R9: latches survive, no join
      step('0, '0, 1, 0, 0); step(3'b010, '0, 0, 1, 0);
      #1; check("R9 cell1 active", 32'(bal_drive), 32'h1);
      step('0, '0, 1, 0, 0); step(3'b001, '0, 0, 1, 0);
      #1; check("R9 no join", 32'(bal_drive), 32'h1);
      step('0, 3'b010, 0, 0, 0);
      #1; check("R9 released", 32'(bal_drive), 32'h3);
      step('0, '0, 0, 1, 0);
      #1; check("R9 latches kept", 32'(bal_drive), 32'h0);

      // R8: sleep mid-balance
      cell_ov = '0; cell_at_target = '0; poll_start = 0; poll_done = 0; sleep = 1;
      #1; check("R8 sleep drive", 32'(bal_drive), 32'h3);
      check("R8 sleep hold", 32'(charge_hold), 32'h0);
      @(posedge clk); model_edge(); @(negedge clk);
      step('0, '0, 0, 1, 0);
      #1; check("R8 latches cleared", 32'(bal_drive), 32'h3);
      idle(2);

      // random phase
      for (int k = 0; k < 4000; k++) begin
         ov = '0; tg = '0;
         for (int b = 0; b < N; b++) begin
            ov[b] = ($urandom % 10) == 0;
            tg[b] = ($urandom % 6) == 0;
         end
         step(ov, tg, ($urandom % 12) == 0, ($urandom % 8) == 0, ($urandom % 80) == 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule